// File: doc/BRIEF.md
# Indexed Register Window with Command Queue

This block is the host-side front end of a 2D drawing engine. The host sees only two locations. Offset 0 holds a register index. Offset 4 is a data window onto whichever engine register that index selects. A data write to an ordinary engine register becomes one command entry, made of the index and the data, and goes into a 64-entry queue. The drawing engine drains the queue through a valid/ready handshake, so the host can keep issuing parameters while earlier drawing work is still running.

Two local registers are never queued. The status register reports, live, how many queue slots are free, whether the engine is idle, and whether a write was lost. The control register holds an interrupt threshold and an interrupt enable. With these the host can either busy-wait until a whole command's parameters fit, or sleep until the interrupt says enough room has opened. A drawing command is a run of parameter writes ending with a line-end write. Each queue entry whose index is the line-end register is flagged on the engine side as the start trigger.

Top module: `gfx_cmd_frontend`

## Requirements
- R1: After reset, `eng_valid` and `irq_o` are low and the status word reads 64 free slots, idle set and overflow clear.
- R2: A write at offset 0 loads the index. A read at offset 0 returns the index, zero-extended to 32 bits.
- R3: A data write at offset 4 to any index other than status (0xF0) or control (0xF1) is queued. Entries reach the engine in write order, and an entry is held stable while `eng_ready` is low.
- R4: `eng_start` is high with an entry exactly when that entry's index is the line-end register 0x2C.
- R5: A queued write that arrives when all 64 slots are taken is dropped without any effect on the queue or the stored values, and it sets the overflow flag (status bit 9). The flag stays set until a control write with bit 9 set clears it.
- R6: The status word at index 0xF0 holds the free-slot count in bits 6:0, idle in bit 8 and overflow in bit 9. Idle is set only when the queue is empty and `eng_busy` is low. Writes to the status index are ignored.
- R7: A data read of any index other than status or control returns the last accepted write to that index.
- R8: The control word at index 0xF1 holds the threshold in bits 6:0 and the interrupt enable in bit 8, and it reads back those two fields. `irq_o` goes high one cycle after the enable is set while the free count is at least the threshold, and it is low otherwise.
- R9: Writes to the status and control indices never produce an engine entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_sel | input | 1 | Host access strobe |
| host_wr | input | 1 | 1 for a write, 0 for a read |
| host_addr | input | 3 | Byte offset: 0 selects the index, 4 selects the data window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Combinational read data for the current address |
| eng_valid | output | 1 | A queued entry is available |
| eng_ready | input | 1 | The engine takes the entry on this edge |
| eng_idx | output | 8 | Register index of the head entry |
| eng_data | output | 32 | Data of the head entry |
| eng_start | output | 1 | The head entry is a line-end trigger |
| eng_busy | input | 1 | The engine is still executing |
| irq_o | output | 1 | Free-space interrupt |

## Verification
A wrong queue count shows up at once in the status word: the free count the host reads or the idle bit is off, and a false full either drops a write early or stores one too many. A corrupted pointer or storage word comes out at the engine side as a reordered or changed entry. The scoreboard catches this on the very handshake that delivers it. A broken overflow flag or threshold comparison shows on the next status read, or one cycle later on `irq_o`. The bench steps the drain one entry at a time across the threshold to pin down that cycle.

// File: rtl/gfx_fe_pkg.sv
// Package: shared widths, register indices and status field positions for
// the drawing-engine host front end. Assumes CNT_W fits below bit 8.
package gfx_fe_pkg;
    localparam int IDX_W = 8;
    localparam int DAT_W = 32;

    localparam logic [IDX_W-1:0] STATUS_IDX   = 8'hF0;
    localparam logic [IDX_W-1:0] CTRL_IDX     = 8'hF1;
    localparam logic [IDX_W-1:0] LINE_END_IDX = 8'h2C;

    localparam int BIT_IDLE = 8;
    localparam int BIT_OVF  = 9;
    localparam int BIT_IEN  = 8;
    localparam int BIT_CLR  = 9;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [DAT_W-1:0] data;
    } cmd_t;
endpackage

// File: rtl/gfx_cmd_fifo.sv
// Command queue: synchronous FIFO with first-word fall-through output.
// Assumes DEPTH is a power of two. A push into a full queue is refused here,
// and the caller flags it.
module gfx_cmd_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 40,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt_q;
    logic do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];
    assign count   = cnt_q;

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    AST_CNT_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R3
    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !pop) |=> (!empty && $stable(rdata))); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH)); // R5
endmodule

// File: rtl/gfx_shadow_regs.sv
// Mirror of the last accepted value of each engine register, so that data
// reads can be served without asking the engine. Read is combinational.
module gfx_shadow_regs #(
    parameter int IDX_W = 8,
    parameter int DAT_W = 32,
    localparam int NREG = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [DAT_W-1:0] wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [DAT_W-1:0] rdata
);
    logic [DAT_W-1:0] mem [NREG];

    // Record each accepted queued write.
    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/gfx_fe_status.sv
// Local control/status state: interrupt threshold and enable, the sticky
// overflow flag and the registered free-space interrupt.
module gfx_fe_status #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic [CNT_W-1:0] ctrl_thr,
    input  logic             ctrl_en,
    input  logic             ctrl_clr,
    input  logic             ovf_set,
    input  logic [CNT_W-1:0] free_cnt,
    output logic [CNT_W-1:0] thr,
    output logic             irq_en,
    output logic             ovf,
    output logic             irq_o
);
    // Control fields load on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr    <= '0;
            irq_en <= 1'b0;
        end else if (ctrl_we) begin
            thr    <= ctrl_thr;
            irq_en <= ctrl_en;
        end
    end

    // Sticky overflow: a set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ovf <= 1'b0;
        else if (ovf_set)            ovf <= 1'b1;
        else if (ctrl_we && ctrl_clr) ovf <= 1'b0;
    end

    // Interrupt follows enable and free space, one cycle late.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= irq_en && (free_cnt >= thr);
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(ctrl_we && ctrl_clr)) |=> ovf); // R5
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(irq_en)); // R8
endmodule

// File: rtl/gfx_cmd_frontend.sv
// Host front end of a 2D drawing engine: index/data window, command queue
// toward the engine, shadowed read-back and live status. Assumes one host
// access per cycle; host_rdata is valid in the same cycle as the address.
module gfx_cmd_frontend
    import gfx_fe_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int CW    = IDX_W + DAT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_sel,
    input  logic             host_wr,
    input  logic [2:0]       host_addr,
    input  logic [DAT_W-1:0] host_wdata,
    output logic [DAT_W-1:0] host_rdata,
    output logic             eng_valid,
    input  logic             eng_ready,
    output logic [IDX_W-1:0] eng_idx,
    output logic [DAT_W-1:0] eng_data,
    output logic             eng_start,
    input  logic             eng_busy,
    output logic             irq_o
);
    logic [IDX_W-1:0] idx_q;
    logic wr_index, wr_data, is_stat, is_ctrl, q_push, fifo_empty, fifo_full;
    logic ovf, irq_en;
    logic [CNT_W-1:0] fifo_cnt, free_cnt, thr;
    logic [DAT_W-1:0] shadow_rd, status_word, ctrl_word;
    cmd_t push_cmd, head_cmd;

    assign wr_index = host_sel && host_wr && (host_addr == 3'd0);
    assign wr_data  = host_sel && host_wr && (host_addr == 3'd4);
    assign is_stat  = (idx_q == STATUS_IDX);
    assign is_ctrl  = (idx_q == CTRL_IDX);
    assign q_push   = wr_data && !is_stat && !is_ctrl;
    assign free_cnt = CNT_W'(DEPTH) - fifo_cnt;

    // Index register.
    always_ff @(posedge clk) begin
        if (!rst_n)        idx_q <= '0;
        else if (wr_index) idx_q <= host_wdata[IDX_W-1:0];
    end

    assign push_cmd = '{idx: idx_q, data: host_wdata};

    gfx_cmd_fifo #(.DEPTH(DEPTH), .W(CW)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .wdata (push_cmd),
        .pop   (eng_ready),
        .rdata (head_cmd),
        .empty (fifo_empty),
        .full  (fifo_full),
        .count (fifo_cnt)
    );

    gfx_shadow_regs #(.IDX_W(IDX_W), .DAT_W(DAT_W)) u_shadow (
        .clk   (clk),
        .we    (q_push && !fifo_full),
        .widx  (idx_q),
        .wdata (host_wdata),
        .ridx  (idx_q),
        .rdata (shadow_rd)
    );

    gfx_fe_status #(.CNT_W(CNT_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_we  (wr_data && is_ctrl),
        .ctrl_thr (host_wdata[CNT_W-1:0]),
        .ctrl_en  (host_wdata[BIT_IEN]),
        .ctrl_clr (host_wdata[BIT_CLR]),
        .ovf_set  (q_push && fifo_full),
        .free_cnt (free_cnt),
        .thr      (thr),
        .irq_en   (irq_en),
        .ovf      (ovf),
        .irq_o    (irq_o)
    );

    assign eng_valid = !fifo_empty;
    assign eng_idx   = head_cmd.idx;
    assign eng_data  = head_cmd.data;
    assign eng_start = eng_valid && (head_cmd.idx == LINE_END_IDX);

    // Assemble the live status and control words.
    always_comb begin
        status_word = '0;
        status_word[CNT_W-1:0] = free_cnt;
        status_word[BIT_IDLE]  = fifo_empty && !eng_busy;
        status_word[BIT_OVF]   = ovf;
        ctrl_word = '0;
        ctrl_word[CNT_W-1:0] = thr;
        ctrl_word[BIT_IEN]   = irq_en;
    end

    // Host read multiplexer.
    always_comb begin
        host_rdata = '0;
        if (host_addr == 3'd0)      host_rdata = DAT_W'(idx_q);
        else if (host_addr == 3'd4) host_rdata = is_stat ? status_word
                                               : is_ctrl ? ctrl_word : shadow_rd;
    end

    AST_DROP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (q_push && fifo_full) |=> ovf); // R5
    AST_LOCAL_NOT_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && (is_stat || is_ctrl) && fifo_empty && !eng_ready) |=> !eng_valid); // R9
endmodule

// File: tb/test_gfx_cmd_frontend.sv
module test_gfx_cmd_frontend;
    localparam int DEPTH = 64;
    localparam logic [7:0] ST = 8'hF0, CT = 8'hF1, LE = 8'h2C;

    logic clk = 0, rst_n = 0;
    logic host_sel = 0, host_wr = 0, eng_ready = 0, eng_busy = 0;
    logic [2:0] host_addr = 0;
    logic [31:0] host_wdata = 0, host_rdata, eng_data;
    logic eng_valid, eng_start, irq_o;
    logic [7:0] eng_idx;

    int vectors = 0, errors = 0, mcnt = 0;
    bit done = 0;
    logic [39:0] expq [$];

    always #2 clk = ~clk;

    gfx_cmd_frontend i_gfx_cmd_frontend (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_idx(eng_idx),
        .eng_data(eng_data), .eng_start(eng_start), .eng_busy(eng_busy),
        .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FIFO FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        host_sel = 0; host_wr = 0;
    endtask

    task automatic hread(input logic [2:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        host_sel = 1; host_wr = 0; host_addr = a;
        @(negedge clk);
        d = host_rdata;
        host_sel = 0;
    endtask

    // Driver: write one register and predict its queue entry.
    task automatic wreg(input logic [7:0] idx, input logic [31:0] d);
        hwrite(3'd0, {24'd0, idx});
        if (idx != ST && idx != CT && mcnt < DEPTH) begin
            expq.push_back({idx, d});
            mcnt++;
        end
        hwrite(3'd4, d);
    endtask

    task automatic rreg(input logic [7:0] idx, output logic [31:0] d);
        hwrite(3'd0, {24'd0, idx});
        hread(3'd4, d);
    endtask

    // Monitor: compare every engine handshake against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && eng_valid && eng_ready) begin
            if (expq.size() == 0) chk(0, "R3 unexpected entry", eng_idx, 0);
            else begin
                logic [39:0] e;
                e = expq.pop_front();
                mcnt--;
                chk({eng_idx, eng_data} == e, "R3 entry order/content", {eng_idx, eng_data}, e);
                chk(eng_start == (e[39:32] == LE), "R4 start flag", eng_start, e[39:32] == LE);
            end
        end
    end

    task automatic drain();
        eng_ready = 1;
        while (expq.size() != 0) @(posedge clk);
        repeat (2) @(posedge clk);
        #1 eng_ready = 0;
    endtask

    task automatic pulse_ready(input int n);
        @(posedge clk); #1 eng_ready = 1;
        repeat (n) @(posedge clk);
        #1 eng_ready = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (5) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(eng_valid == 0, "R1 eng_valid after reset", eng_valid, 0);
        chk(irq_o == 0, "R1 irq after reset", irq_o, 0);
        rreg(ST, d);
        chk(d[6:0] == 64 && d[8] && !d[9], "R1 status after reset", d, 32'h140);

        hwrite(3'd0, 32'h0000_005A);
        hread(3'd0, d);
        chk(d == 32'h5A, "R2 index readback", d, 32'h5A);

        eng_ready = 1;
        wreg(8'h10, 32'h00FF_0000);
        wreg(8'h11, 32'h1234_5678);
        wreg(8'h2B, 32'h0010_0020);
        wreg(LE, 32'h0040_0080);
        drain();
        chk(expq.size() == 0, "R3 all entries delivered", expq.size(), 0);
        rreg(8'h11, d);
        chk(d == 32'h1234_5678, "R7 shadow readback", d, 32'h1234_5678);

        eng_busy = 1;
        rreg(ST, d);
        chk(d[8] == 0, "R6 idle low while engine busy", d[8], 0);
        eng_busy = 0;
        hread(3'd4, d);
        chk(d[8] == 1, "R6 idle high when empty and not busy", d[8], 1);

        wreg(CT, 32'd10);
        @(negedge clk);
        chk(eng_valid == 0, "R9 control write not queued", eng_valid, 0);
        rreg(CT, d);
        chk(d == 32'd10, "R8 control readback", d, 32'd10);
        wreg(ST, 32'hFFFF_FFFF);
        @(negedge clk);
        chk(eng_valid == 0, "R9 status write not queued", eng_valid, 0);
        rreg(ST, d);
        chk(d[9] == 0 && d[6:0] == 64, "R6 status write ignored", d, 32'h140);

        // Fill the queue with the engine stalled.
        wreg(8'h10, 32'h0000_A0A0);
        for (int i = 1; i < DEPTH; i++) wreg(8'h20 + 8'(i % 8), 32'(i));
        @(negedge clk);
        chk(eng_valid && eng_idx == 8'h10 && eng_data == 32'hA0A0, "R3 head held while stalled",
            eng_data, 32'hA0A0);
        rreg(ST, d);
        chk(d[6:0] == 0 && d[8] == 0 && d[9] == 0, "R6 status when full", d, 0);
        wreg(8'h10, 32'h0000_DEAD);
        rreg(ST, d);
        chk(d[9] == 1 && d[6:0] == 0, "R5 overflow flag on drop", d, 32'h200);
        rreg(8'h10, d);
        chk(d == 32'hA0A0, "R5 dropped write leaves shadow", d, 32'hA0A0);

        wreg(CT, 32'h0000_010A);
        repeat (3) @(negedge clk);
        chk(irq_o == 0, "R8 irq low while full", irq_o, 0);
        pulse_ready(9);
        repeat (3) @(negedge clk);
        chk(irq_o == 0, "R8 irq low at 9 free", irq_o, 0);
        pulse_ready(1);
        repeat (2) @(negedge clk);
        chk(irq_o == 1, "R8 irq high at threshold", irq_o, 1);
        rreg(ST, d);
        chk(d[9] == 1 && d[6:0] == 10, "R5 overflow sticky", d, 32'h20A);
        wreg(CT, 32'h0000_030A);
        rreg(ST, d);
        chk(d[9] == 0, "R5 overflow cleared by control", d[9], 0);
        wreg(CT, 32'h0000_000A);
        repeat (2) @(negedge clk);
        chk(irq_o == 0, "R8 irq low when disabled", irq_o, 0);

        wreg(8'h2B, 32'h0001_0001);
        wreg(LE, 32'h0002_0002);
        drain();
        chk(expq.size() == 0 && eng_valid == 0, "R3 queue drained", expq.size(), 0);
        finish_run();
    end
endmodule